// File: doc/BRIEF.md
# Load-Use and Branch Interlock Controller

This block is the stall and bubble controller of a five-stage in-order pipeline with separate instruction and data memories. Each cycle it compares the source registers of the instruction sitting in decode against the destination of a load currently in execute. When the decode instruction needs a value that the load has not yet produced, the controller freezes the program counter and the fetch/decode register for one cycle. It also zeroes the control fields entering the decode/execute register, so a harmless empty slot travels down the pipe and the dependent instruction picks up the loaded value through forwarding one cycle later.

Conditional branches are resolved late, and no prediction is made. When a branch leaves decode, the controller stops fetching and squashes what enters the fetch/decode register for a fixed number of cycles. The default is two, and it is set by the parameter `BR_BUBBLES`. The outside PC select logic then steers fetch to the resolved target. If a load-use hazard and a branch meet in the same cycle, the load-use interlock is served first and the branch is held in decode. The branch window starts on the following cycle, so every bubble is inserted once and no instruction is dropped or fetched twice.

All control outputs are combinational functions of the current inputs and one small down-counter. Memory traffic in the later stages never stalls fetch.

Top module: `hazard_interlock`

## Requirements
- R1: When `ex_mem_read_i` is 1, `ex_rd_i` is nonzero, `id_valid_i` is 1, no branch window is active, and an enabled decode source (`id_rs_use_i`/`id_rs_i` or `id_rt_use_i`/`id_rt_i`) equals `ex_rd_i`, the controller drives `pc_we_o`=0, `ifid_we_o`=0, `idex_bubble_o`=1 and `ifid_flush_o`=0 in that same cycle.
- R2: The load-use stall lasts exactly one cycle. Once execute holds the bubble (`ex_mem_read_i`=0), the same decode instruction proceeds with `pc_we_o`=1, `ifid_we_o`=1 and `idex_bubble_o`=0.
- R3: No stall is inserted if the execute instruction is not a load, the load targets register 0, the matching source is not enabled, no source matches, or `id_valid_i` is 0. In that case the outputs are `pc_we_o`=1, `ifid_we_o`=1, `ifid_flush_o`=0 and `idex_bubble_o`=0.
- R4: A valid branch in decode (`id_branch_i`=1) that has no load-use hazard opens a window of exactly `BR_BUBBLES` cycles, starting with that cycle. In each cycle of the window `pc_we_o`=0, `ifid_we_o`=1, `ifid_flush_o`=1 and `idex_bubble_o`=0. The cycle after the window returns to normal flow.
- R5: During the branch window after its first cycle, the decode inputs are ignored. A load-use match or a further branch indication neither adds a stall nor extends the window.
- R6: A branch that also has a load-use hazard first receives the one-cycle load-use stall, with no flush. It then opens its `BR_BUBBLES`-cycle window on the next cycle in which it is hazard-free, for 1 + `BR_BUBBLES` bubble cycles in total.
- R7: While `rst_ni` is 0 and on the first cycle after release, with idle inputs, the outputs are `pc_we_o`=1, `ifid_we_o`=1, `ifid_flush_o`=0 and `idex_bubble_o`=0. Reset also cancels any open branch window.
- R8: `idex_bubble_o` and `ifid_flush_o` are never 1 together, and `pc_we_o` is 0 whenever either is 1.
- R9: In a pipeline steered by these outputs, seven branch-free instructions take 11 cycles from first fetch to last write-back when no instruction directly follows a load it reads. The same work takes 13 cycles when it contains two adjacent load-use pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | Decode stage holds a real instruction |
| id_rs_use_i | input | 1 | Decode instruction reads its first source |
| id_rs_i | input | REG_W | First source register number |
| id_rt_use_i | input | 1 | Decode instruction reads its second source |
| id_rt_i | input | REG_W | Second source register number |
| id_branch_i | input | 1 | Decode instruction is a conditional branch |
| ex_mem_read_i | input | 1 | Execute instruction reads data memory (load) |
| ex_rd_i | input | REG_W | Destination register of the execute instruction |
| pc_we_o | output | 1 | Program counter may advance |
| ifid_we_o | output | 1 | Fetch/decode register may load |
| ifid_flush_o | output | 1 | Fetch/decode register loads an empty slot |
| idex_bubble_o | output | 1 | Decode/execute register loads zeroed control (bubble) |

## Verification
Every output is due in the same cycle as the inputs that cause it. The bench therefore drives a vector just after a falling edge and samples the outputs a nanosecond later, well before the next rising edge. The branch window counter advances on the rising edge, so window cycles two onward show up in the following table rows, one row per clock. The cycle-count requirement is checked with a small bench-side pipeline model that moves its stage contents only at rising edges, according to the sampled outputs. The model counts the cycles from the first fetch until the last instruction reaches write-back.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    // One cycle of pipeline steering
    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic ifid_flush;
        logic idex_bubble;
    } hz_ctl_t;

    localparam hz_ctl_t CTL_RUN = '{pc_we: 1'b1, ifid_we: 1'b1, ifid_flush: 1'b0, idex_bubble: 1'b0};
    localparam hz_ctl_t CTL_LU  = '{pc_we: 1'b0, ifid_we: 1'b0, ifid_flush: 1'b0, idex_bubble: 1'b1};
    localparam hz_ctl_t CTL_BR  = '{pc_we: 1'b0, ifid_we: 1'b1, ifid_flush: 1'b1, idex_bubble: 1'b0};

    localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
    parameter int unsigned REG_W = 5
) (
    input  logic             src_use_i,
    input  logic [REG_W-1:0] src_i,
    input  logic             ld_i,
    input  logic [REG_W-1:0] ld_rd_i,
    output logic             hit_o
);
    logic rd_live;

    always_comb begin
        rd_live = ld_i && (ld_rd_i != '0);
        hit_o   = rd_live && src_use_i && (src_i == ld_rd_i);
    end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
    import hazard_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  logic                     valid_i,
    input  logic [NUM_SRC-1:0]       use_i,
    input  logic [NUM_SRC-1:0][REG_W-1:0] src_i,
    input  logic                     ld_i,
    input  logic [REG_W-1:0]         ld_rd_i,
    output logic                     hazard_o
);
    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        hz_src_match #(.REG_W(REG_W)) u_match (
            .src_use_i (use_i[g]),
            .src_i     (src_i[g]),
            .ld_i      (ld_i),
            .ld_rd_i   (ld_rd_i),
            .hit_o     (hit[g])
        );
    end

    always_comb begin
        hazard_o = valid_i && (|hit);
    end
endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
    import hazard_pkg::*;
#(
    parameter int unsigned REG_W      = 5,
    parameter int unsigned BR_BUBBLES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             id_valid_i,
    input  logic             id_rs_use_i,
    input  logic [REG_W-1:0] id_rs_i,
    input  logic             id_rt_use_i,
    input  logic [REG_W-1:0] id_rt_i,
    input  logic             id_branch_i,
    input  logic             ex_mem_read_i,
    input  logic [REG_W-1:0] ex_rd_i,
    output logic             pc_we_o,
    output logic             ifid_we_o,
    output logic             ifid_flush_o,
    output logic             idex_bubble_o
);
    localparam int unsigned CNT_W = $clog2(BR_BUBBLES + 1);
    localparam logic [CNT_W-1:0] WIN_RELOAD = CNT_W'(BR_BUBBLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] win_left;
    } state_t;

    state_t  st_d, st_q;
    hz_ctl_t ctl_d;

    logic [NUM_SRC-1:0]            src_use;
    logic [NUM_SRC-1:0][REG_W-1:0] src_reg;
    logic                          lu_hazard;
    logic                          win_busy;

    always_comb begin
        src_use = {id_rt_use_i, id_rs_use_i};
        src_reg = {id_rt_i, id_rs_i};
    end

    hz_load_use #(.REG_W(REG_W)) u_lu (
        .valid_i  (id_valid_i),
        .use_i    (src_use),
        .src_i    (src_reg),
        .ld_i     (ex_mem_read_i),
        .ld_rd_i  (ex_rd_i),
        .hazard_o (lu_hazard)
    );

    always_comb begin
        st_d     = st_q;
        ctl_d    = CTL_RUN;
        win_busy = (st_q.win_left != '0);
        if (win_busy) begin
            // decode holds a squashed slot: its fields do not matter
            ctl_d         = CTL_BR;
            st_d.win_left = st_q.win_left - 1'b1;
        end else if (lu_hazard) begin
            // load-use wins; a branch in decode waits one cycle
            ctl_d = CTL_LU;
        end else if (id_valid_i && id_branch_i) begin
            ctl_d         = CTL_BR;
            st_d.win_left = WIN_RELOAD;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        pc_we_o       = ctl_d.pc_we;
        ifid_we_o     = ctl_d.ifid_we;
        ifid_flush_o  = ctl_d.ifid_flush;
        idex_bubble_o = ctl_d.idex_bubble;
    end
endmodule

// File: rtl/hazard_interlock_chk.sv
module hazard_interlock_chk #(
    parameter int unsigned BR_BUBBLES = 2
) (
    input logic clk_i,
    input logic rst_ni,
    input logic ex_mem_read_i,
    input logic pc_we_o,
    input logic ifid_we_o,
    input logic ifid_flush_o,
    input logic idex_bubble_o
);
    localparam int unsigned RUN_W = $clog2(BR_BUBBLES + 1);

    logic [RUN_W-1:0] run_q;

    // counts flush cycles modulo the window length
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q <= '0;
        end else if (ifid_flush_o) begin
            run_q <= (run_q == RUN_W'(BR_BUBBLES - 1)) ? '0 : run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    AST_LU_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idex_bubble_o |-> (!pc_we_o && !ifid_we_o)); // R1

    AST_NO_LOAD_NO_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ex_mem_read_i |-> !idex_bubble_o); // R3

    AST_FLUSH_HOLDS_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ifid_flush_o |-> (!pc_we_o && ifid_we_o)); // R4

    AST_WINDOW_WHOLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ifid_flush_o |-> (run_q == '0)); // R4

    AST_BUBBLE_FLUSH_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(idex_bubble_o && ifid_flush_o)); // R8

    AST_RESET_RUN: assert property (@(posedge clk_i)
        !rst_ni |-> (pc_we_o && ifid_we_o && !ifid_flush_o && !idex_bubble_o)); // R7
endmodule

bind hazard_interlock hazard_interlock_chk #(.BR_BUBBLES(BR_BUBBLES)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ex_mem_read_i (ex_mem_read_i),
    .pc_we_o       (pc_we_o),
    .ifid_we_o     (ifid_we_o),
    .ifid_flush_o  (ifid_flush_o),
    .idex_bubble_o (idex_bubble_o)
);

// File: tb/tb_hazard_interlock.sv
module tb_hazard_interlock;
    localparam int REG_W = 5;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic id_valid = 1'b0, id_rs_use = 1'b0, id_rt_use = 1'b0, id_branch = 1'b0;
    logic ex_mem_read = 1'b0;
    logic [REG_W-1:0] id_rs = '0, id_rt = '0, ex_rd = '0;
    logic pc_we, ifid_we, ifid_flush, idex_bubble;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    hazard_interlock #(.REG_W(REG_W), .BR_BUBBLES(2)) dut (
        .clk_i(clk), .rst_ni(rst_ni),
        .id_valid_i(id_valid), .id_rs_use_i(id_rs_use), .id_rs_i(id_rs),
        .id_rt_use_i(id_rt_use), .id_rt_i(id_rt), .id_branch_i(id_branch),
        .ex_mem_read_i(ex_mem_read), .ex_rd_i(ex_rd),
        .pc_we_o(pc_we), .ifid_we_o(ifid_we), .ifid_flush_o(ifid_flush),
        .idex_bubble_o(idex_bubble)
    );

    // expected outputs packed as {pc_we, ifid_we, flush, bubble}
    typedef struct packed {
        logic       v;
        logic       rsu;
        logic [4:0] rs;
        logic       rtu;
        logic [4:0] rt;
        logic       ld;
        logic [4:0] exrd;
        logic       br;
        logic [3:0] exp;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 4'b1100, 8'd3}, // R3 idle
        '{1'b1, 1'b1, 5'd5, 1'b1, 5'd6, 1'b1, 5'd5, 1'b0, 4'b0001, 8'd1}, // R1 rs hit
        '{1'b1, 1'b1, 5'd7, 1'b1, 5'd5, 1'b1, 5'd5, 1'b0, 4'b0001, 8'd1}, // R1 rt hit
        '{1'b1, 1'b0, 5'd5, 1'b1, 5'd6, 1'b1, 5'd5, 1'b0, 4'b1100, 8'd3}, // R3 unused src
        '{1'b1, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b0, 4'b1100, 8'd3}, // R3 reg 0
        '{1'b1, 1'b1, 5'd5, 1'b1, 5'd5, 1'b0, 5'd5, 1'b0, 4'b1100, 8'd3}, // R3 not a load
        '{1'b0, 1'b1, 5'd5, 1'b1, 5'd5, 1'b1, 5'd5, 1'b0, 4'b1100, 8'd3}, // R3 id invalid
        '{1'b1, 1'b1, 5'd5, 1'b1, 5'd6, 1'b0, 5'd0, 1'b0, 4'b1100, 8'd2}, // R2 after stall
        '{1'b1, 1'b1, 5'd1, 1'b1, 5'd2, 1'b0, 5'd0, 1'b1, 4'b0110, 8'd4}, // R4 branch
        '{1'b1, 1'b1, 5'd9, 1'b1, 5'd2, 1'b1, 5'd9, 1'b1, 4'b0110, 8'd5}, // R5 ignored in window
        '{1'b1, 1'b1, 5'd1, 1'b1, 5'd2, 1'b0, 5'd0, 1'b0, 4'b1100, 8'd4}, // R4 window closed
        '{1'b1, 1'b1, 5'd5, 1'b0, 5'd2, 1'b1, 5'd5, 1'b1, 4'b0001, 8'd6}, // R6 branch + load-use
        '{1'b1, 1'b1, 5'd5, 1'b0, 5'd2, 1'b0, 5'd0, 1'b1, 4'b0110, 8'd6}, // R6 window opens
        '{1'b1, 1'b1, 5'd5, 1'b0, 5'd2, 1'b0, 5'd0, 1'b1, 4'b0110, 8'd6}, // R6 second bubble
        '{1'b1, 1'b1, 5'd3, 1'b1, 5'd4, 1'b0, 5'd0, 1'b0, 4'b1100, 8'd6}  // R6 resume
    };

    typedef struct packed {
        logic [4:0] rs;
        logic       rsu;
        logic [4:0] rt;
        logic       rtu;
        logic [4:0] rd;
        logic       ld;
    } ins_t;

    // $t0..$t5 = 8..13; lw: base only, sw: base + data, add: two sources
    localparam ins_t PROG_SLOW [7] = '{
        '{5'd8,  1'b1, 5'd0,  1'b0, 5'd9,  1'b1},
        '{5'd8,  1'b1, 5'd0,  1'b0, 5'd10, 1'b1},
        '{5'd9,  1'b1, 5'd10, 1'b1, 5'd11, 1'b0},
        '{5'd8,  1'b1, 5'd11, 1'b1, 5'd0,  1'b0},
        '{5'd8,  1'b1, 5'd0,  1'b0, 5'd12, 1'b1},
        '{5'd9,  1'b1, 5'd12, 1'b1, 5'd13, 1'b0},
        '{5'd8,  1'b1, 5'd13, 1'b1, 5'd0,  1'b0}
    };
    localparam ins_t PROG_FAST [7] = '{
        '{5'd8,  1'b1, 5'd0,  1'b0, 5'd9,  1'b1},
        '{5'd8,  1'b1, 5'd0,  1'b0, 5'd10, 1'b1},
        '{5'd8,  1'b1, 5'd0,  1'b0, 5'd12, 1'b1},
        '{5'd9,  1'b1, 5'd10, 1'b1, 5'd11, 1'b0},
        '{5'd8,  1'b1, 5'd11, 1'b1, 5'd0,  1'b0},
        '{5'd9,  1'b1, 5'd12, 1'b1, 5'd13, 1'b0},
        '{5'd8,  1'b1, 5'd13, 1'b1, 5'd0,  1'b0}
    };

    task automatic check4(input logic [3:0] exp, input int req, input string what);
        logic [3:0] act;
        act = {pc_we, ifid_we, ifid_flush, idex_bubble};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        id_valid = 0; id_rs_use = 0; id_rt_use = 0; id_branch = 0;
        ex_mem_read = 0; id_rs = '0; id_rt = '0; ex_rd = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_ni = 0;
        repeat (2) @(negedge clk);
        rst_ni = 1;
    endtask

    function automatic ins_t fetch(input bit slow, input int i);
        return slow ? PROG_SLOW[i] : PROG_FAST[i];
    endfunction

    task automatic run_prog(input bit slow, output int cycles);
        int pc = 0, fd = -1, ex = -1, mem = -1, wb = -1;
        ins_t ii;
        cycles = -1;
        for (int c = 1; c < 60; c++) begin
            if (wb == 6) begin
                cycles = c;
                break;
            end
            @(negedge clk);
            id_branch = 0;
            id_valid = (fd >= 0);
            if (fd >= 0) begin
                ii = fetch(slow, fd);
                id_rs = ii.rs; id_rs_use = ii.rsu; id_rt = ii.rt; id_rt_use = ii.rtu;
            end else begin
                id_rs = '0; id_rs_use = 0; id_rt = '0; id_rt_use = 0;
            end
            if (ex >= 0) begin
                ii = fetch(slow, ex);
                ex_mem_read = ii.ld; ex_rd = ii.rd;
            end else begin
                ex_mem_read = 0; ex_rd = '0;
            end
            #1;
            wb  = mem;
            mem = ex;
            ex  = idex_bubble ? -1 : fd;
            if (ifid_flush)   fd = -1;
            else if (ifid_we) fd = (pc < 7) ? pc : -1;
            if (pc_we) pc++;
            @(posedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int cyc;
        // R7 during reset
        idle_inputs();
        #2;
        check4(4'b1100, 7, "in reset");
        repeat (2) @(negedge clk);
        rst_ni = 1;
        #1;
        check4(4'b1100, 7, "first cycle after reset");

        // vector table: one row per clock
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            id_valid = VEC[i].v; id_rs_use = VEC[i].rsu; id_rs = VEC[i].rs;
            id_rt_use = VEC[i].rtu; id_rt = VEC[i].rt; ex_mem_read = VEC[i].ld;
            ex_rd = VEC[i].exrd; id_branch = VEC[i].br;
            #1;
            check4(VEC[i].exp, int'(VEC[i].req), $sformatf("vector %0d", i));
        end

        // R7: reset cancels an open branch window
        @(negedge clk);
        idle_inputs();
        id_valid = 1; id_branch = 1;
        #1;
        check4(4'b0110, 4, "branch before reset");
        rst_ni = 0;
        #1;
        idle_inputs();
        @(negedge clk);
        rst_ni = 1;
        #1;
        check4(4'b1100, 7, "window cleared by reset");

        // R4: consecutive windows stay whole
        @(negedge clk);
        id_valid = 1; id_branch = 1;
        #1; check4(4'b0110, 4, "branch A cycle 1");
        @(negedge clk); #1; check4(4'b0110, 4, "branch A cycle 2");
        @(negedge clk); #1; check4(4'b0110, 4, "branch B cycle 1");
        @(negedge clk); id_branch = 0; #1; check4(4'b0110, 4, "branch B cycle 2");
        @(negedge clk); #1; check4(4'b1100, 4, "after two windows");

        // R9: sequence timing
        do_reset();
        run_prog(1'b1, cyc);
        checks++;
        if (cyc != 13) begin
            fails++;
            $display("FAIL R9 two load-use pairs: actual %0d expected 13", cyc);
        end
        do_reset();
        run_prog(1'b0, cyc);
        checks++;
        if (cyc != 11) begin
            fails++;
            $display("FAIL R9 scheduled order: actual %0d expected 11", cyc);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule